// File: doc/BRIEF.md
# Transmit Packet Gate with Cut-Through

This block is a single-clock buffer placed ahead of a 10G Ethernet MAC transmitter. An AXI4-Stream of 64-bit words, each with four user bits and a last flag, is written into an internal FIFO. The MAC side has no backpressure: once a word is presented as valid, the MAC takes it in the same cycle. The gate therefore keeps the output shut until it is safe to release. It opens when the FIFO holds at least one whole frame, so the MAC cannot run dry in the middle of a frame.

With the `CUT_THRESH` parameter set above zero, the block can also start a frame early. Once the number of buffered words rises above the threshold, a cut-through flag is set and data flows before the frame's last word has arrived. The flag drops when the MAC takes a word marked last. In this mode the buffer is sized from the threshold rather than for a full maximum-length frame.

User bit 3 marks the first word of a frame. User bits 2:0 give the number of valid bytes in the word. A stored-frame counter, the FIFO and the cut-through flag make up the whole block.

Top module: `tx_pkt_gate`

## Requirements
- R1: Every accepted word is presented on the output exactly once, in acceptance order, with its 64 data bits, 4 user bits and last flag unchanged.
- R2: While no complete frame is stored and the cut-through flag is clear, `m_valid` is 0. When a word with `s_tlast`=1 is accepted at a clock edge, `m_valid` is 1 in the cycle that follows that edge.
- R3: `s_tready` is 0 exactly when the FIFO is full. A word offered while `s_tready` is 0 is not stored and never appears on the output.
- R4: The stored-frame count rises on each accepted last word and falls on each last word sent. A last word written in the same cycle as a last word is read leaves the count unchanged, and the gate stays open for the frame just written.
- R5: The FIFO depth is 1024 words when `CUT_THRESH`=0 and 2^(ceil(log2 CUT_THRESH)+1) words otherwise.
- R6: With `CUT_THRESH`=N>0, the cut-through flag sets at the edge where the occupancy before the edge is strictly greater than N. `m_valid` rises in the cycle after that edge, even though no last word is stored.
- R7: The cut-through flag clears at the edge where the MAC takes a valid word with `m_eof`=1. After that, a partial frame at or below the threshold is held back again.
- R8: `m_bytes` equals stored user bits 2:0 and `m_eof` equals the stored last flag. `m_sof` equals stored user bit 3 and is only 1 while `m_valid` is 1. The FIFO read advances only when the gate is open.
- R9: When the set condition of R6 and the clear condition of R7 hold in the same cycle, the flag ends up set.
- R10: Synchronous active-low reset empties the FIFO, zeroes the frame count and clears the flag. After reset, `m_valid`=0 and `s_tready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tvalid | input | 1 | Input word valid |
| s_tready | output | 1 | Input ready (FIFO not full) |
| s_tdata | input | 64 | Input data word |
| s_tuser | input | 4 | Bit 3 start of frame, bits 2:0 valid byte count |
| s_tlast | input | 1 | Last word of frame |
| m_valid | output | 1 | Word presented to the MAC (taken the same cycle) |
| m_data | output | 64 | Output data word |
| m_bytes | output | 3 | Valid byte count of the output word |
| m_sof | output | 1 | Start of frame, gated by the release condition |
| m_eof | output | 1 | Last word of frame |

## Verification
The bench runs two instances, one with threshold 5 and one in pure store-and-forward mode, against a reference model of occupancy, frame count and flag.

- **Gate opening too early or too late.** A gate that opened one cycle early would leak a partial frame to the MAC. One that opened one cycle late would show as a `m_valid` mismatch in the cycle after the last word is accepted.
- **Threshold compare.** The bench pauses at exactly N words and then adds one more. A design using greater-or-equal instead of strictly-greater would release at N words.
- **Flag priority.** A long frame is streamed straight into a second one so that the first frame's last word leaves while occupancy is still above N. A design with clear-over-set priority would put a one-cycle hole in `m_valid`.
- **Full FIFO.** The store-mode instance is filled to exactly 1024 words and then offered a stray word. A lost full flag would make that word surface in the output stream.

// File: rtl/tpg_pkg.sv
// Package: shared word layout and sizing helpers for the transmit packet gate.
// Assumes a fixed 64-bit data path with a 4-bit user field and a last flag.
package tpg_pkg;

    localparam int DATA_W   = 64;
    localparam int USER_W   = 4;
    localparam int BYTES_W  = 3;
    localparam int STORE_AW = 10;   // address bits when cut-through is off
    localparam int SOF_BIT  = 3;    // user bit carrying start of frame

    // One stored entry: {last, user, data}, 69 bits in total.
    typedef struct packed {
        logic              last;
        logic [USER_W-1:0] user;
        logic [DATA_W-1:0] data;
    } tpg_word_t;

    // Address width of the FIFO for a given cut-through threshold.
    function automatic int gate_aw(input int thresh);
        return (thresh > 0) ? ($clog2(thresh) + 1) : STORE_AW;
    endfunction

endpackage

// File: rtl/tpg_fifo.sv
// Module: tpg_fifo
// First-word-fall-through FIFO for gate entries. The head entry is visible on
// rd_word whenever empty is low. Writes while full and reads while empty are
// dropped. The storage array carries no reset; only pointers and count do.
module tpg_fifo
    import tpg_pkg::*;
#(
    parameter int AW = 10
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  tpg_word_t   wr_word,
    input  logic        rd_en,
    output tpg_word_t   rd_word,
    output logic        full,
    output logic        empty,
    output logic [AW:0] occ
);

    localparam int          DEPTH   = 1 << AW;
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    tpg_word_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [AW:0]     count;
    logic            do_wr;
    logic            do_rd;

    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;

    // Store the incoming entry at the write pointer.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_word;
        end
    end

    // Advance the write pointer on every stored entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (do_wr) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // Advance the read pointer on every consumed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (do_rd) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Track the number of stored entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rd_word = mem[rd_ptr];
    assign full    = (count == DEPTH_V);
    assign empty   = (count == '0);
    assign occ     = count;

endmodule

// File: rtl/tpg_pkt_count.sv
// Module: tpg_pkt_count
// Counts complete frames held in the FIFO: +1 per last word written,
// -1 per last word read, no change when both happen together.
// Assumes the caller only signals events that the FIFO actually performs.
module tpg_pkt_count #(
    parameter int CW = 11
)(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_last,
    input  logic rd_last,
    output logic has_pkt
);

    logic [CW-1:0] frames;

    // Update the stored-frame count from write and read events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frames <= '0;
        end else begin
            case ({wr_last, rd_last})
                2'b10:   frames <= frames + 1'b1;
                2'b01:   frames <= frames - 1'b1;
                default: frames <= frames;
            endcase
        end
    end

    assign has_pkt = (frames != '0);

endmodule

// File: rtl/tpg_cut_ctrl.sv
// Module: tpg_cut_ctrl
// Cut-through flag. Sets when occupancy is strictly above THRESH. Clears when
// the MAC takes a last word. Set wins over clear. With THRESH = 0 the flag
// does not exist and the output is tied low.
module tpg_cut_ctrl #(
    parameter int THRESH = 0,
    parameter int OW     = 11
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [OW-1:0] occ,
    input  logic          eof_taken,
    output logic          cut_on
);

    generate
        if (THRESH > 0) begin : g_cut
            localparam logic [OW-1:0] THRESH_V = OW'(THRESH);
            logic flag_q;
            logic cut_start;

            assign cut_start = (occ > THRESH_V);

            // Hold the flag from threshold crossing until the frame ends.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (cut_start) begin
                    flag_q <= 1'b1;
                end else if (eof_taken) begin
                    flag_q <= 1'b0;
                end
            end

            assign cut_on = flag_q;
        end else begin : g_no_cut
            logic unused_in;
            assign unused_in = clk ^ rst_n ^ eof_taken ^ (^occ);
            assign cut_on    = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/tx_pkt_gate.sv
// Module: tx_pkt_gate
// Transmit packet gate: buffers a 64-bit AXI4-Stream and releases it to a MAC
// that cannot stall. Release happens when a whole frame is stored, or when
// the cut-through flag is set. Assumes a single clock domain and that the MAC
// takes every word presented with m_valid high.
module tx_pkt_gate
    import tpg_pkg::*;
#(
    parameter int CUT_THRESH = 0
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_tvalid,
    output logic               s_tready,
    input  logic [DATA_W-1:0]  s_tdata,
    input  logic [USER_W-1:0]  s_tuser,
    input  logic               s_tlast,
    output logic               m_valid,
    output logic [DATA_W-1:0]  m_data,
    output logic [BYTES_W-1:0] m_bytes,
    output logic               m_sof,
    output logic               m_eof
);

    localparam int AW = gate_aw(CUT_THRESH);
    localparam int OW = AW + 1;

    tpg_word_t     in_word;
    tpg_word_t     head;
    logic          fifo_full;
    logic          fifo_empty;
    logic [OW-1:0] fifo_occ;
    logic          wr_fire;
    logic          rd_fire;
    logic          pkt_present;
    logic          cut_on;
    logic          gate_open;

    assign in_word = '{last: s_tlast, user: s_tuser, data: s_tdata};
    assign wr_fire = s_tvalid && !fifo_full;

    tpg_fifo #(.AW(AW)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_fire),
        .wr_word (in_word),
        .rd_en   (gate_open),
        .rd_word (head),
        .full    (fifo_full),
        .empty   (fifo_empty),
        .occ     (fifo_occ)
    );

    tpg_pkt_count #(.CW(OW)) u_pkt_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_last (wr_fire && s_tlast),
        .rd_last (rd_fire && head.last),
        .has_pkt (pkt_present)
    );

    tpg_cut_ctrl #(.THRESH(CUT_THRESH), .OW(OW)) u_cut (
        .clk       (clk),
        .rst_n     (rst_n),
        .occ       (fifo_occ),
        .eof_taken (rd_fire && head.last),
        .cut_on    (cut_on)
    );

    // Release condition and MAC-side outputs.
    always_comb begin
        gate_open = pkt_present || cut_on;
        rd_fire   = gate_open && !fifo_empty;
        m_valid   = rd_fire;
        m_data    = head.data;
        m_bytes   = head.user[BYTES_W-1:0];
        m_sof     = rd_fire && head.user[SOF_BIT];
        m_eof     = head.last;
    end

    assign s_tready = !fifo_full;

endmodule

// File: rtl/tx_pkt_gate_chk.sv
// Module: tx_pkt_gate_chk
// Property checker for tx_pkt_gate, attached with bind. Observes ports plus
// the occupancy, frame-present and cut-through state of the gate.
module tx_pkt_gate_chk #(
    parameter int THRESH = 0,
    parameter int OW     = 11
)(
    input logic          clk,
    input logic          rst_n,
    input logic          s_tvalid,
    input logic          s_tready,
    input logic          s_tlast,
    input logic          m_valid,
    input logic          m_sof,
    input logic          m_eof,
    input logic [OW-1:0] occ,
    input logic          pkt_present,
    input logic          cut_on
);

    localparam logic [OW-1:0] DEPTH_V = OW'(1 << (OW - 1));

    // R2: no release while the gate condition is false
    assert_gate_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_present && !cut_on) |-> !m_valid);

    // R3: a full FIFO with no read keeps its occupancy
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_tready && !m_valid) |=> $stable(occ));

    // R4: an accepted last word always leaves a frame counted
    assert_pkt_counted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready && s_tlast) |=> pkt_present);

    // R5: occupancy never exceeds the configured depth
    assert_occ_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_V);

    // R8: start of frame only appears with valid
    assert_sof_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        m_sof |-> m_valid);

    // R10: after a reset cycle the output is idle and input ready
    assert_reset_state_R10: assert property (@(posedge clk)
        !rst_n |=> (!m_valid && s_tready));

    generate
        if (THRESH > 0) begin : g_cut_props
            localparam logic [OW-1:0] TH_V = OW'(THRESH);

            // R6: occupancy above threshold sets the flag
            assert_cut_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (occ > TH_V) |=> cut_on);

            // R7: last word taken at or below threshold clears the flag
            assert_cut_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (m_valid && m_eof && occ <= TH_V) |=> !cut_on);

            // R9: set wins when set and clear coincide
            assert_set_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (cut_on && m_valid && m_eof && occ > TH_V) |=> cut_on);
        end else begin : g_store_props
            // R6: no cut-through exists in store-and-forward mode
            assert_no_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !cut_on);
        end
    endgenerate

endmodule

bind tx_pkt_gate tx_pkt_gate_chk #(.THRESH(CUT_THRESH), .OW(OW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_tvalid    (s_tvalid),
    .s_tready    (s_tready),
    .s_tlast     (s_tlast),
    .m_valid     (m_valid),
    .m_sof       (m_sof),
    .m_eof       (m_eof),
    .occ         (fifo_occ),
    .pkt_present (pkt_present),
    .cut_on      (cut_on)
);

// File: tb/tx_pkt_gate_tb.sv
// Bench: two gates (threshold 5 and store-and-forward) against a reference
// model of occupancy, frame count, flag and word order.
module tx_pkt_gate_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic        rst_n;
    logic        sv   [2];
    logic [63:0] sd   [2];
    logic [3:0]  su   [2];
    logic        sl   [2];
    logic        srdy [2];
    logic        mv   [2];
    logic [63:0] mdat [2];
    logic [2:0]  mbyt [2];
    logic        msof [2];
    logic        meof [2];

    int checks = 0;
    int fails  = 0;

    tx_pkt_gate #(.CUT_THRESH(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .s_tvalid(sv[0]), .s_tready(srdy[0]),
        .s_tdata(sd[0]), .s_tuser(su[0]), .s_tlast(sl[0]), .m_valid(mv[0]),
        .m_data(mdat[0]), .m_bytes(mbyt[0]), .m_sof(msof[0]), .m_eof(meof[0]));

    tx_pkt_gate #(.CUT_THRESH(0)) u_dut_sf (
        .clk(clk), .rst_n(rst_n), .s_tvalid(sv[1]), .s_tready(srdy[1]),
        .s_tdata(sd[1]), .s_tuser(su[1]), .s_tlast(sl[1]), .m_valid(mv[1]),
        .m_data(mdat[1]), .m_bytes(mbyt[1]), .m_sof(msof[1]), .m_eof(meof[1]));

    // Reference model state
    int          occ_m  [2];
    int          pkt_m  [2];
    bit          flag_m [2];
    logic [68:0] q0 [$];
    logic [68:0] q1 [$];
    bit          snap_v   [2];
    bit          snap_rdy [2];
    logic [68:0] snap_w   [2];

    function automatic int th(input int i);
        return (i == 0) ? 5 : 0;
    endfunction

    function automatic int dep(input int i);
        return (i == 0) ? 16 : 1024;
    endfunction

    function automatic bit exp_valid(input int i);
        return (occ_m[i] > 0) && (pkt_m[i] > 0 || flag_m[i]);
    endfunction

    function automatic logic [68:0] front(input int i);
        if (i == 0) return (q0.size() > 0) ? q0[0] : '0;
        return (q1.size() > 0) ? q1[0] : '0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [68:0] act,
                         input logic [68:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs with the model away from the active edge; snapshot inputs.
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            snap_rdy[i] = srdy[i];
            if (rst_n) begin
                check(mv[i] == exp_valid(i), "R2/R6/R7/R9 m_valid", 69'(mv[i]),
                      69'(exp_valid(i)));
                check(srdy[i] == (occ_m[i] < dep(i)), "R3/R5 s_tready",
                      69'(srdy[i]), 69'(occ_m[i] < dep(i)));
                if (mv[i] && exp_valid(i)) begin
                    check({meof[i], msof[i], mbyt[i], mdat[i]} ==
                          {front(i)[68], front(i)[67], front(i)[66:64], front(i)[63:0]},
                          "R1/R8 output word",
                          69'({meof[i], msof[i], 1'b0, mbyt[i], mdat[i]}), front(i));
                end
                snap_v[i] = sv[i];
                snap_w[i] = {sl[i], su[i], sd[i]};
            end else begin
                snap_v[i] = 1'b0;
                snap_w[i] = '0;
            end
        end
    end

    // Advance the model on each edge from its own view of reads and writes.
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                occ_m[i]  = 0;
                pkt_m[i]  = 0;
                flag_m[i] = 1'b0;
                if (i == 0) q0.delete(); else q1.delete();
            end else begin
                bit rd;
                bit wr;
                bit rd_eof;
                rd     = exp_valid(i);
                rd_eof = rd && front(i)[68];
                wr     = snap_v[i] && (occ_m[i] < dep(i));
                if (th(i) > 0) begin
                    if (occ_m[i] > th(i)) flag_m[i] = 1'b1;
                    else if (rd_eof)      flag_m[i] = 1'b0;
                end
                occ_m[i] = occ_m[i] + int'(wr) - int'(rd);
                pkt_m[i] = pkt_m[i] + int'(wr && snap_w[i][68]) - int'(rd_eof);
                if (i == 0) begin
                    if (rd) void'(q0.pop_front());
                    if (wr) q0.push_back(snap_w[i]);
                end else begin
                    if (rd) void'(q1.pop_front());
                    if (wr) q1.push_back(snap_w[i]);
                end
            end
        end
    end

    // Offer one word and hold it until accepted; returns at posedge + 1.
    task automatic send(input int i, input logic [63:0] d, input logic [3:0] u,
                        input bit l);
        sv[i] = 1'b1; sd[i] = d; su[i] = u; sl[i] = l;
        forever begin
            @(posedge clk);
            if (snap_rdy[i]) break;
        end
        #1;
        sv[i] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Check m_valid / s_tready at the next negedge, return at next posedge + 1.
    task automatic probe(input int i, input bit exp_mv, input bit exp_rdy,
                         input string tag);
        @(negedge clk);
        check(mv[i] == exp_mv, tag, 69'(mv[i]), 69'(exp_mv));
        check(srdy[i] == exp_rdy, tag, 69'(srdy[i]), 69'(exp_rdy));
        @(posedge clk);
        #1;
    endtask

    // Frame of len words: first word has user bit 3, last word a byte count.
    task automatic send_pkt(input int i, input int len, input int gap_pct,
                            input bit close);
        for (int k = 0; k < len; k++) begin
            bit          lst;
            logic [3:0]  u;
            lst = close && (k == len - 1);
            u   = {k == 0, lst ? 3'($urandom_range(0, 7)) : 3'd0};
            send(i, {$urandom, $urandom}, u, lst);
            if (int'($urandom_range(0, 99)) < gap_pct) idle(int'($urandom_range(1, 3)));
        end
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 2; i++) begin
            sv[i] = 1'b0; sd[i] = '0; su[i] = '0; sl[i] = 1'b0;
        end
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        // R10: idle after reset
        probe(0, 1'b0, 1'b1, "R10 reset state cut");
        probe(1, 1'b0, 1'b1, "R10 reset state store");

        // R2: store mode holds a partial frame, releases right after last
        send_pkt(1, 3, 0, 1'b0);
        idle(5);
        probe(1, 1'b0, 1'b1, "R2 partial frame held");
        send(1, 64'h1111_2222_3333_4444, 4'b0101, 1'b1);
        probe(1, 1'b1, 1'b1, "R2 release after last");
        idle(10);

        // R6: threshold 5 is strict
        send(0, 64'hA0, 4'b1000, 1'b0);
        send_pkt(0, 4, 0, 1'b0);
        idle(6);
        probe(0, 1'b0, 1'b1, "R6 five words held");
        send(0, 64'hA5, 4'b0000, 1'b0);
        probe(0, 1'b0, 1'b1, "R6 flag not yet set");
        probe(0, 1'b1, 1'b1, "R6 cut-through release");
        idle(10);
        send(0, 64'hA6, 4'b0000, 1'b0);
        send(0, 64'hA7, 4'b0011, 1'b1);
        idle(4);
        // R7: flag cleared, new partial frame held
        send(0, 64'hB0, 4'b1000, 1'b0);
        send_pkt(0, 2, 0, 1'b0);
        idle(5);
        probe(0, 1'b0, 1'b1, "R7 held after flag clear");
        send_pkt(0, 3, 0, 1'b1);
        idle(10);

        // R9: last of a long frame leaves while occupancy stays above 5
        send(0, 64'hC0, 4'b1000, 1'b0);
        send_pkt(0, 9, 0, 1'b1);
        send(0, 64'hD0, 4'b1000, 1'b0);
        send_pkt(0, 12, 0, 1'b1);
        idle(30);

        // R5 / R3: fill the store-mode FIFO to exactly 1024 words
        send(1, 64'hE000, 4'b1000, 1'b0);
        for (int k = 1; k < 1023; k++) send(1, 64'hE000 + 64'(k), 4'b0000, 1'b0);
        probe(1, 1'b0, 1'b1, "R5 1023 words stored, not full, R2 held");
        send(1, 64'hEFFF, 4'b0110, 1'b1);
        sv[1] = 1'b1; sd[1] = 64'hDEAD_BEEF; su[1] = 4'b1111; sl[1] = 1'b1;
        probe(1, 1'b1, 1'b0, "R3/R5 full at 1024");
        sv[1] = 1'b0;
        idle(1100);

        // R4: random traffic with gaps on both gates
        for (int p = 0; p < 40; p++) begin
            send_pkt(0, int'($urandom_range(1, 20)), 30, 1'b1);
            send_pkt(1, int'($urandom_range(1, 20)), 30, 1'b1);
        end
        idle(200);
        checks++;
        if (q0.size() != 0 || q1.size() != 0) begin
            fails++;
            $display("FAIL R1/R4 frames left actual=%0d expected=0", q0.size() + q1.size());
        end

        // R10: reset discards a partial frame
        send_pkt(0, 3, 0, 1'b0);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        probe(0, 1'b0, 1'b1, "R10 reset mid-frame");
        idle(5);
        probe(0, 1'b0, 1'b1, "R10 nothing released after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule